// File: doc/BRIEF.md
# Critical-Doubleword-First Line Fill Sequencer

This block services one cache miss at a time by filling a 32-byte line over a 64-bit memory bus. The requester offers a byte address and a store-through flag. The sequencer then issues a single burst request on the bus. The request carries the line-aligned base address and the index of the doubleword that holds the missing byte. The bus returns four 64-bit beats. The first beat is the critical doubleword, and the remaining doublewords follow in wrap-around order within the line.

The critical beat goes straight back to the requester on the same cycle it is accepted. This lets the load complete before the rest of the line arrives. Each beat is written into its own slot of a line buffer. After the fourth beat, the assembled line is offered to the cache array in natural order, together with the base address and the flag.

The sequencer has three streams, and each uses a valid/ready handshake:
- Miss in: a transfer happens on a cycle where both `miss_valid` and `miss_ready` are high.
- Beats in: a beat is taken on a cycle where both `beat_valid` and `beat_ready` are high.
- Line out: the line is taken on a cycle where both `line_valid` and `line_ready` are high.

The bus request follows the same rule. Any side may stall for any number of cycles. While its partner is stalled, an offered transfer is held unchanged.

Top module: `line_fill_seq`

## Requirements
- R1: After reset, `miss_ready` is 1 and `bus_req_valid`, `beat_ready`, `crit_valid` and `line_valid` are all 0.
- R2: A miss is taken on a cycle with `miss_valid` and `miss_ready` both high. From the next cycle, `miss_ready` stays 0 until the line has been handed off.
- R3: The cycle after a miss is taken, `bus_req_valid` rises. `bus_req_addr` equals the miss address with bits [4:0] cleared. `bus_req_crit` equals miss address bits [4:3]. Both stay stable until `bus_req_ready` is seen high.
- R4: `beat_ready` is 1 only after the bus request is accepted and until the fourth beat is taken. The n-th beat taken (counting from 0) belongs to doubleword (crit + n) mod 4 of the line.
- R5: `crit_valid` is high for exactly one cycle: the cycle in which the first beat is taken. On that cycle, `crit_data` equals `beat_data` and `crit_idx` equals the critical index.
- R6: `line_valid` rises the cycle after the fourth beat is taken. `line_data` bits [64k+63:64k] hold the doubleword at byte offset 8k of the line. `line_addr` is the line base.
- R7: `line_wt` carries the store-through flag given with the miss.
- R8: Back-pressure is honoured on every stream:
  - Cycles with `beat_valid` low advance nothing.
  - A stalled request holds its values.
  - While `line_ready` is low, `line_valid`, `line_data`, `line_addr` and `line_wt` do not change.
- R9: The cycle after the line is taken, `line_valid` is 0 and `miss_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request offered |
| miss_ready | output | 1 | Sequencer idle, can take a miss |
| miss_addr | input | 32 | Byte address that missed |
| miss_wt | input | 1 | Store-through flag for the line |
| bus_req_valid | output | 1 | Burst request offered |
| bus_req_ready | input | 1 | Bus accepts the burst request |
| bus_req_addr | output | 32 | Line-aligned burst address |
| bus_req_crit | output | 2 | Doubleword to return first |
| beat_valid | input | 1 | Data beat offered by the bus |
| beat_ready | output | 1 | Sequencer can take a beat |
| beat_data | input | 64 | Data beat |
| crit_valid | output | 1 | Critical doubleword pulse |
| crit_data | output | 64 | Critical doubleword |
| crit_idx | output | 2 | Index of the critical doubleword |
| line_valid | output | 1 | Full line offered to the array |
| line_ready | input | 1 | Array accepts the line |
| line_data | output | 256 | Line, doubleword 0 in the low bits |
| line_addr | output | 32 | Line base address |
| line_wt | output | 1 | Store-through flag of the line |

## Verification
The bench builds the block with its default parameters: a 64-bit bus, four beats and 32-bit addresses. It sweeps every critical index, both values of the store-through flag and three stall patterns on the request, beat and line handshakes. Each of those patterns is paired with a different byte offset inside the doubleword. This covers every wrap-around rotation of the beat order, stalls before and between beats, and a line held under back-pressure, with each doubleword checked against a value computed from its slot and base address.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_DATA = 2'd2,
    FS_LINE = 2'd3
  } fill_state_t;
endpackage

// File: rtl/lfs_ctrl.sv
module lfs_ctrl #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              miss_wt,
  input  logic              bus_req_ready,
  input  logic              beat_valid,
  input  logic              last_beat,
  input  logic              line_ready,
  output logic              miss_ready,
  output logic              start,
  output logic              bus_req_valid,
  output logic              beat_ready,
  output logic              beat_fire,
  output logic              line_valid,
  output logic [ADDR_W-1:0] base_addr,
  output logic [IDX_W-1:0]  crit_q,
  output logic              wt_q
);
  import lfs_pkg::*;

  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((64'd1 << OFF_W) - 64'd1);

  fill_state_t      state, state_n;
  logic [ADDR_W-1:0] addr_q;

  assign miss_ready    = (state == FS_IDLE);
  assign bus_req_valid = (state == FS_REQ);
  assign beat_ready    = (state == FS_DATA);
  assign line_valid    = (state == FS_LINE);
  assign start         = miss_valid && miss_ready;
  assign beat_fire     = beat_valid && beat_ready;

  always_comb begin
    state_n = state;
    case (state)
      FS_IDLE: if (start)                 state_n = FS_REQ;
      FS_REQ:  if (bus_req_ready)         state_n = FS_DATA;
      FS_DATA: if (beat_fire && last_beat) state_n = FS_LINE;
      FS_LINE: if (line_ready)            state_n = FS_IDLE;
      default:                            state_n = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= FS_IDLE;
      addr_q <= '0;
      wt_q   <= 1'b0;
    end else begin
      state <= state_n;
      if (start) begin
        addr_q <= miss_addr;
        wt_q   <= miss_wt;
      end
    end
  end

  assign base_addr = addr_q & ~OFF_MASK;
  assign crit_q    = addr_q[OFF_W-1 -: IDX_W];

  // R2
  miss_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> !miss_ready);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready) |=> (bus_req_valid && $stable(base_addr) && $stable(crit_q)));

  // R8
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && !line_ready) |=> (line_valid && $stable(base_addr) && $stable(wt_q)));

  // R9
  reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && line_ready) |=> (miss_ready && !line_valid));
endmodule

// File: rtl/lfs_beat_ctr.sv
module lfs_beat_ctr #(
  parameter int BEATS = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             beat_fire,
  input  logic [IDX_W-1:0] crit,
  output logic [IDX_W-1:0] slot_idx,
  output logic             first_beat,
  output logic             last_beat
);
  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (start)     cnt <= '0;
    else if (beat_fire) cnt <= cnt + IDX_W'(1);
  end

  // wrap-around order: index is taken modulo the beat count
  assign slot_idx   = crit + cnt;
  assign first_beat = (cnt == '0);
  assign last_beat  = (cnt == IDX_W'(BEATS - 1));

  // R4
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && last_beat) |=> (cnt == '0));
endmodule

// File: rtl/lfs_line_buf.sv
module lfs_line_buf #(
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  parameter int IDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [BEATS-1:0]        slot_v,
  output logic [BEATS*DATA_W-1:0] line_data
);
  logic [DATA_W-1:0] slot_d [BEATS];

  for (genvar k = 0; k < BEATS; k++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot_v[k] <= 1'b0;
      else if (start) slot_v[k] <= 1'b0;
      else if (hit)   slot_v[k] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) slot_d[k] <= wr_data;
    end

    assign line_data[k*DATA_W +: DATA_W] = slot_d[k];
  end

  // R4
  no_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !slot_v[wr_idx]);
endmodule

// File: rtl/line_fill_seq.sv
module line_fill_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  localparam int IDX_W  = $clog2(BEATS),
  localparam int LINE_W = BEATS * DATA_W,
  localparam int OFF_W  = $clog2(LINE_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              miss_wt,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [IDX_W-1:0]  bus_req_crit,
  input  logic              beat_valid,
  output logic              beat_ready,
  input  logic [DATA_W-1:0] beat_data,
  output logic              crit_valid,
  output logic [DATA_W-1:0] crit_data,
  output logic [IDX_W-1:0]  crit_idx,
  output logic              line_valid,
  input  logic              line_ready,
  output logic [LINE_W-1:0] line_data,
  output logic [ADDR_W-1:0] line_addr,
  output logic              line_wt
);
  logic             start, beat_fire, first_beat, last_beat;
  logic [IDX_W-1:0] crit_q, slot_idx;
  logic [ADDR_W-1:0] base_addr;
  logic [BEATS-1:0] slot_v;

  lfs_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_wt(miss_wt),
    .bus_req_ready(bus_req_ready), .beat_valid(beat_valid),
    .last_beat(last_beat), .line_ready(line_ready),
    .miss_ready(miss_ready), .start(start), .bus_req_valid(bus_req_valid),
    .beat_ready(beat_ready), .beat_fire(beat_fire), .line_valid(line_valid),
    .base_addr(base_addr), .crit_q(crit_q), .wt_q(line_wt)
  );

  lfs_beat_ctr #(.BEATS(BEATS), .IDX_W(IDX_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start), .beat_fire(beat_fire),
    .crit(crit_q), .slot_idx(slot_idx), .first_beat(first_beat),
    .last_beat(last_beat)
  );

  lfs_line_buf #(.DATA_W(DATA_W), .BEATS(BEATS), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_en(beat_fire),
    .wr_idx(slot_idx), .wr_data(beat_data), .slot_v(slot_v),
    .line_data(line_data)
  );

  assign bus_req_addr = base_addr;
  assign bus_req_crit = crit_q;
  assign line_addr    = base_addr;
  assign crit_valid   = beat_fire && first_beat;
  assign crit_data    = beat_data;
  assign crit_idx     = crit_q;

  // R5
  crit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crit_valid |=> !crit_valid);

  // R6
  line_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && last_beat) |=> line_valid);

  // R6
  line_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> (&slot_v));

  // R8
  line_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && !line_ready) |=> $stable(line_data));
endmodule

// File: tb/sim_line_fill_seq.sv
module sim_line_fill_seq;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_valid = 0, miss_wt = 0, bus_req_ready = 0, beat_valid = 0, line_ready = 0;
  logic [31:0] miss_addr = '0;
  logic [63:0] beat_data = '0;
  logic miss_ready, bus_req_valid, beat_ready, crit_valid, line_valid, line_wt;
  logic [31:0] bus_req_addr, line_addr;
  logic [1:0] bus_req_crit, crit_idx;
  logic [63:0] crit_data;
  logic [255:0] line_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  line_fill_seq u0 (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_addr(miss_addr), .miss_wt(miss_wt), .bus_req_valid(bus_req_valid),
    .bus_req_ready(bus_req_ready), .bus_req_addr(bus_req_addr),
    .bus_req_crit(bus_req_crit), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_data(beat_data), .crit_valid(crit_valid), .crit_data(crit_data),
    .crit_idx(crit_idx), .line_valid(line_valid), .line_ready(line_ready),
    .line_data(line_data), .line_addr(line_addr), .line_wt(line_wt)
  );

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] dw(input logic [31:0] base, input int k);
    return {base, 32'h5A00_0000 | 32'(k)};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic fill(input int ci, input bit wt, input int st, input int bo);
    logic [31:0] base;
    logic [255:0] exp_line;
    base = 32'h4000_0000 + 32'((ci * 8 + int'(wt) * 4 + st) * 32);
    exp_line = '0;
    for (int k = 0; k < 4; k++) exp_line[k*64 +: 64] = dw(base, k);
    // offer miss
    miss_valid = 1; miss_addr = base | 32'(ci * 8) | 32'(bo); miss_wt = wt;
    #1 chk("R2 miss_ready idle", 256'(miss_ready), 256'(1));
    tick();
    miss_valid = 0; miss_addr = 32'hDEAD_BEEF;
    #1;
    chk("R2 miss_ready low during fill", 256'(miss_ready), 256'(0));
    chk("R3 bus_req_valid", 256'(bus_req_valid), 256'(1));
    chk("R3 bus_req_addr aligned", 256'(bus_req_addr), 256'(base));
    chk("R3 bus_req_crit", 256'(bus_req_crit), 256'(ci));
    chk("R4 beat_ready low before grant", 256'(beat_ready), 256'(0));
    for (int s = 0; s < st; s++) begin
      tick(); #1;
      chk("R8 request held", 256'({bus_req_valid, bus_req_addr, bus_req_crit}),
          256'({1'b1, base, 2'(ci)}));
    end
    bus_req_ready = 1;
    tick();
    bus_req_ready = 0;
    for (int n = 0; n < 4; n++) begin
      for (int s = 0; s < ((st == 2 && n % 2 == 1) ? 2 : st); s++) begin
        #1;
        chk("R8 stall no crit", 256'(crit_valid), 256'(0));
        chk("R8 stall no line", 256'(line_valid), 256'(0));
        tick();
      end
      beat_valid = 1;
      beat_data = dw(base, (ci + n) % 4);
      #1;
      chk("R4 beat_ready in data phase", 256'(beat_ready), 256'(1));
      if (n == 0) begin
        chk("R5 crit_valid on first beat", 256'(crit_valid), 256'(1));
        chk("R5 crit_data", 256'(crit_data), 256'(dw(base, ci)));
        chk("R5 crit_idx", 256'(crit_idx), 256'(ci));
      end else begin
        chk("R5 crit_valid only once", 256'(crit_valid), 256'(0));
      end
      tick();
      beat_valid = 0;
    end
    #1;
    chk("R6 line_valid", 256'(line_valid), 256'(1));
    chk("R4 beat_ready low after fourth", 256'(beat_ready), 256'(0));
    chk("R6 line_data order", line_data, exp_line);
    chk("R6 line_addr", 256'(line_addr), 256'(base));
    chk("R7 line_wt", 256'(line_wt), 256'(wt));
    chk("R2 miss_ready low while line pending", 256'(miss_ready), 256'(0));
    for (int s = 0; s < st + (st == 2 ? 1 : 0); s++) begin
      tick(); #1;
      chk("R8 line held", {line_data}, exp_line);
      chk("R8 line_valid held", 256'({line_valid, line_wt, line_addr}), 256'({1'b1, wt, base}));
    end
    line_ready = 1;
    tick();
    line_ready = 0;
    #1;
    chk("R9 line dropped", 256'(line_valid), 256'(0));
    chk("R9 miss_ready back", 256'(miss_ready), 256'(1));
  endtask

  initial begin
    tick(); tick();
    #1;
    chk("R1 reset miss_ready", 256'(miss_ready), 256'(1));
    chk("R1 reset outputs low",
        256'({bus_req_valid, beat_ready, crit_valid, line_valid}), 256'(0));
    rst_n = 1;
    tick();
    for (int ci = 0; ci < 4; ci++)
      for (int wt = 0; wt < 2; wt++)
        for (int st = 0; st < 3; st++)
          fill(ci, wt[0], st, (ci + st * 3 + wt) % 8);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule